// File: doc/BRIEF.md
# Link Transmit and Receive Timeout Watchdog

This block guards a serial display link against two kinds of stall. One timer measures how long the link stays in a high-speed transmit burst. A second, independent timer measures how long the link waits for a low-power response from the far end. Both timers count in transmit byte-clock cycles, and both use one shared prescaler. The prescaler divides by a power of two, so a single select field trades resolution for range on both timers at once.

A controller pulses a start strobe when a burst or a receive wait begins, and a stop strobe when it ends. If a timer reaches its programmed limit before the stop strobe arrives, the block raises a sticky error flag. The flag stays high until a write-one-to-clear strobe lowers it. A neighbouring status register places the transmit flag at its bit 6 and the receive flag at its bit 7. A limit of zero turns the matching timer off.

Top module: `link_timeout_guard`

## Requirements
- R1: After a synchronous reset, both error flags read 0 and the prescaler phase counter is 0.
- R2: `hs_cfg` bits [3:0] hold the prescale select and bits [21:4] hold the 18-bit transmit-burst limit. `rx_limit` holds the receive-wait limit.
- R3: A free-running 15-bit phase counter p starts at 0 after reset and increments every cycle. A count tick occurs in each cycle where the low `sel` bits of p are all ones. With `sel`=0 a tick occurs in every cycle, so one count unit lasts 2^sel cycles.
- R4: In a transmit burst with limit L>0, `err_flags[0]` (status bit 6) rises at the clock edge that takes the L-th tick after the edge that sampled `hs_start`.
- R5: The receive timer follows the same rule with `rx_start`, `rx_stop`, `rx_limit` and `err_flags[1]` (status bit 7), and it uses the same prescaler ticks.
- R6: A stop strobe halts its timer. A wait that has been stopped never raises the flag, and the timer stays idle until its next start strobe.
- R7: A start strobe while the timer runs resets the count to zero. When start and stop arrive in the same cycle, start wins.
- R8: An error flag stays set until the bit of `err_clr` at the same index is 1 at a clock edge. If an expiry happens at the same edge as the clear, the flag stays set.
- R9: A limit of zero disables its timer, and that flag never rises.
- R10: The two timers are independent. Activity on one never changes the other's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_cfg | input | 22 | [3:0] prescale select, [21:4] transmit-burst limit |
| rx_limit | input | 18 | Receive-wait limit |
| hs_start | input | 1 | Pulse: a high-speed burst begins |
| hs_stop | input | 1 | Pulse: a high-speed burst ends |
| rx_start | input | 1 | Pulse: a receive wait begins |
| rx_stop | input | 1 | Pulse: a receive wait ends |
| err_clr | input | 2 | Write-one-to-clear, [0] transmit flag, [1] receive flag |
| err_flags | output | 2 | Sticky timeout flags, [0] transmit (status bit 6), [1] receive (status bit 7) |

## Verification
Every flag is registered. A flag changes at the same rising edge that takes the expiring tick or samples a clear, so a start strobe sampled at edge k with `sel`=0 and limit L shows its flag right after edge k+L. The bench drives inputs on falling edges. Its behavioural model steps on the same rising edge as the design, and the bench compares the outputs at the next falling edge, once per cycle. Directed checks at the expected edge, and one edge before it, pin down the exact latency, the priority of set over clear and the priority of start over stop.

// File: rtl/link_timeout_pkg.sv
package link_timeout_pkg;
  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned CH_HS   = 0;
  localparam int unsigned CH_RX   = 1;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PH_W = (1 << SEL_W) - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] low_mask;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  // the low 'sel' bits of the phase must all be ones for a tick
  always_comb begin
    low_mask = ~({PH_W{1'b1}} << sel);
    tick     = &(phase | ~low_mask);
  end
endmodule

// File: rtl/lt_channel.sv
module lt_channel #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] limit,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             clr,
  output logic             flag
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_nxt;
  logic             advance;
  logic             hit;

  always_comb begin
    cnt_nxt = {1'b0, cnt} + 1'b1;
    advance = active && !start && !stop && (limit != '0) && tick;
    hit     = advance && (cnt_nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      flag   <= 1'b0;
    end else begin
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (stop) begin
        active <= 1'b0;
      end else if (advance) begin
        cnt <= cnt_nxt[CNT_W-1:0];
        if (hit) active <= 1'b0;
      end
      flag <= (flag && !clr) || hit;
    end
  end
endmodule

// File: rtl/link_timeout_guard.sv
module link_timeout_guard #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned HS_W  = 18,
  parameter int unsigned RX_W  = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [HS_W+SEL_W-1:0] hs_cfg,
  input  logic [RX_W-1:0]       rx_limit,
  input  logic                  hs_start,
  input  logic                  hs_stop,
  input  logic                  rx_start,
  input  logic                  rx_stop,
  input  logic [1:0]            err_clr,
  output logic [1:0]            err_flags
);
  import link_timeout_pkg::*;

  localparam int unsigned CH_W = max_w(HS_W, RX_W);

  logic [SEL_W-1:0] sel;
  logic             tick;
  logic [CH_W-1:0]  lim   [NUM_CH];
  logic [NUM_CH-1:0] starts;
  logic [NUM_CH-1:0] stops;

  always_comb begin
    sel          = hs_cfg[SEL_W-1:0];
    lim[CH_HS]   = CH_W'(hs_cfg[HS_W+SEL_W-1:SEL_W]);
    lim[CH_RX]   = CH_W'(rx_limit);
    starts       = {rx_start, hs_start};
    stops        = {rx_stop,  hs_stop};
  end

  lt_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel),
    .tick (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lt_channel #(.CNT_W(CH_W)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .limit (lim[c]),
      .tick  (tick),
      .start (starts[c]),
      .stop  (stops[c]),
      .clr   (err_clr[c]),
      .flag  (err_flags[c])
    );
  end
endmodule

// File: rtl/link_timeout_guard_chk.sv
module link_timeout_guard_chk #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned HS_W  = 18,
  parameter int unsigned RX_W  = 18
) (
  input logic                  clk,
  input logic                  rst,
  input logic [HS_W+SEL_W-1:0] hs_cfg,
  input logic [RX_W-1:0]       rx_limit,
  input logic                  hs_start,
  input logic                  hs_stop,
  input logic                  rx_start,
  input logic                  rx_stop,
  input logic [1:0]            err_clr,
  input logic [1:0]            err_flags
);
  logic hs_zero;
  assign hs_zero = (hs_cfg[HS_W+SEL_W-1:SEL_W] == '0);

  // R1: flags are low right after reset
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> err_flags == 2'b00);

  // R8: sticky flags
  p_sticky_hs_r8: assert property (@(posedge clk) disable iff (rst)
    (err_flags[0] && !err_clr[0]) |=> err_flags[0]);
  p_sticky_rx_r8: assert property (@(posedge clk) disable iff (rst)
    (err_flags[1] && !err_clr[1]) |=> err_flags[1]);

  // R9: zero limit never raises a flag
  p_zero_hs_r9: assert property (@(posedge clk) disable iff (rst)
    (hs_zero && !err_flags[0]) |=> !err_flags[0]);
  p_zero_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_limit == '0 && !err_flags[1]) |=> !err_flags[1]);

  // R6: a stop strobe never coincides with an expiry
  p_stop_quiet_hs_r6: assert property (@(posedge clk) disable iff (rst)
    (hs_stop && !hs_start && !err_flags[0]) |=> !err_flags[0]);
  p_stop_quiet_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_stop && !rx_start && !err_flags[1]) |=> !err_flags[1]);

  // R7: a start strobe together with a clear leaves the flag low
  p_start_reload_hs_r7: assert property (@(posedge clk) disable iff (rst)
    (hs_start && err_clr[0]) |=> !err_flags[0]);
  p_start_reload_rx_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_start && err_clr[1]) |=> !err_flags[1]);
endmodule

bind link_timeout_guard link_timeout_guard_chk #(
  .SEL_W(SEL_W), .HS_W(HS_W), .RX_W(RX_W)
) u_chk (
  .clk(clk), .rst(rst), .hs_cfg(hs_cfg), .rx_limit(rx_limit),
  .hs_start(hs_start), .hs_stop(hs_stop), .rx_start(rx_start), .rx_stop(rx_stop),
  .err_clr(err_clr), .err_flags(err_flags)
);

// File: tb/link_timeout_guard_bench.sv
`timescale 1ns/1ps
module link_timeout_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [21:0] hs_cfg = '0;
  logic [17:0] rx_limit = '0;
  logic        hs_start = 0, hs_stop = 0, rx_start = 0, rx_stop = 0;
  logic [1:0]  err_clr = '0;
  logic [1:0]  err_flags;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  link_timeout_guard u_link_timeout_guard (
    .clk(clk), .rst(rst), .hs_cfg(hs_cfg), .rx_limit(rx_limit),
    .hs_start(hs_start), .hs_stop(hs_stop), .rx_start(rx_start), .rx_stop(rx_stop),
    .err_clr(err_clr), .err_flags(err_flags)
  );

  // behavioural reference model
  int m_phase;
  int m_act [2];
  int m_cnt [2];
  int m_flg [2];

  always @(posedge clk) begin
    int sel, lim [2];
    bit tk, st [2], sp [2];
    if (rst) begin
      m_phase = 0;
      for (int c = 0; c < 2; c++) begin m_act[c] = 0; m_cnt[c] = 0; m_flg[c] = 0; end
    end else begin
      sel = int'(hs_cfg[3:0]);
      lim[0] = int'(hs_cfg[21:4]);
      lim[1] = int'(rx_limit);
      st[0] = hs_start; st[1] = rx_start;
      sp[0] = hs_stop;  sp[1] = rx_stop;
      tk = (sel == 0) ? 1'b1 : ((m_phase % (1 << sel)) == (1 << sel) - 1);
      for (int c = 0; c < 2; c++) begin
        bit ex;
        ex = 0;
        if (st[c]) begin m_act[c] = 1; m_cnt[c] = 0; end
        else if (sp[c]) m_act[c] = 0;
        else if (m_act[c] != 0 && lim[c] != 0 && tk) begin
          m_cnt[c]++;
          if (m_cnt[c] >= lim[c]) begin ex = 1; m_act[c] = 0; end
        end
        m_flg[c] = ((m_flg[c] != 0) && !err_clr[c]) || ex;
      end
      m_phase = (m_phase + 1) % 32768;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, " flag0"}, int'(err_flags[0]), m_flg[0]);
      check({cur_req, " flag1"}, int'(err_flags[1]), m_flg[1]);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulse_hs_start();  hs_start = 1; step(); hs_start = 0; endtask
  task automatic pulse_rx_start();  rx_start = 1; step(); rx_start = 0; endtask
  task automatic clear_all();       err_clr = 2'b11; step(); err_clr = 2'b00; endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); step(2); rst = 0;
    check("R1 reset flags", int'(err_flags), 0);

    // R4: sel 0, limit 5: flag due right after edge k+5
    cur_req = "R4";
    hs_cfg = {18'd5, 4'd0};
    pulse_hs_start();            // edge k
    step(4);
    check("R4 one edge early", int'(err_flags[0]), 0);
    step();
    check("R4 at limit", int'(err_flags[0]), 1);
    step(5);
    check("R8 sticky", int'(err_flags[0]), 1);

    // R8: clear lowers the flag
    cur_req = "R8";
    clear_all();
    check("R8 cleared", int'(err_flags[0]), 0);

    // R8: set wins over clear in the same edge
    hs_cfg = {18'd3, 4'd0};
    pulse_hs_start();
    step(2);
    err_clr = 2'b01; step(); err_clr = 2'b00;
    check("R8 set beats clear", int'(err_flags[0]), 1);
    clear_all();

    // R6: stop before limit
    cur_req = "R6";
    hs_cfg = {18'd6, 4'd0};
    pulse_hs_start();
    step(3);
    hs_stop = 1; step(); hs_stop = 0;
    step(20);
    check("R6 stopped no flag", int'(err_flags[0]), 0);

    // R7: restart reloads; start beats stop
    cur_req = "R7";
    hs_cfg = {18'd4, 4'd0};
    pulse_hs_start();
    step(3);
    hs_start = 1; hs_stop = 1; step(); hs_start = 0; hs_stop = 0;
    step(3);
    check("R7 reload not expired", int'(err_flags[0]), 0);
    step();
    check("R7 expiry after restart", int'(err_flags[0]), 1);
    clear_all();

    // R2/R3: prescaled transmit limit
    cur_req = "R3";
    hs_cfg = {18'd3, 4'd2};
    pulse_hs_start();
    step(16);
    check("R2 prescaled flag", int'(err_flags[0]), m_flg[0]);
    check("R3 expired by 3x4 cycles", int'(err_flags[0]), 1);
    clear_all();

    // R5: receive timer with shared prescaler, R10 independence
    cur_req = "R5";
    hs_cfg = {18'd0, 4'd3};
    rx_limit = 18'd2;
    pulse_rx_start();
    step(20);
    check("R5 rx flag", int'(err_flags[1]), 1);
    check("R10 hs untouched", int'(err_flags[0]), 0);
    err_clr = 2'b10; step(); err_clr = 2'b00;
    check("R5 rx cleared", int'(err_flags[1]), 0);

    // R9: zero limits disable both
    cur_req = "R9";
    rx_limit = 18'd0;
    hs_cfg = {18'd0, 4'd0};
    pulse_hs_start(); pulse_rx_start();
    step(60);
    check("R9 both disabled", int'(err_flags), 0);
    hs_stop = 1; rx_stop = 1; step(); hs_stop = 0; rx_stop = 0;

    // R10: hs expiry while rx waits
    cur_req = "R10";
    hs_cfg = {18'd2, 4'd0};
    rx_limit = 18'd40;
    pulse_rx_start(); pulse_hs_start();
    step(4);
    check("R10 hs set, rx running", int'(err_flags), 1);
    rx_stop = 1; step(); rx_stop = 0;
    clear_all();

    // R3: widest select, limit 1
    cur_req = "R3";
    hs_cfg = {18'd1, 4'd15};
    pulse_hs_start();
    step(33000);
    check("R3 sel 15 tick", int'(err_flags[0]), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule